// File: doc/BRIEF.md
# Retriggerable Digital One-Shot Timer

This block is a clocked monostable pulse generator. It watches two trigger lines. `trig_up` fires on a rising edge, but only while `trig_dn` is high. `trig_dn` fires on a falling edge, but only while `trig_up` is low. An accepted trigger drives `pulse_q` high for a fixed number of clock cycles and holds `pulse_qn` at the exact complement.

A down-counter loaded from `PERIOD_CYCLES` sets the pulse length. A short lockout of `LOCKOUT_CYCLES` follows every accepted trigger; the lockout cycles count as part of the pulse. Once the lockout has ended, a new trigger reloads the full period while the pulse is still running, unless `single_shot` is set. When `single_shot` is set, every pulse lasts exactly one period.

The `clear_n` input aborts a pulse at once. After the registers leave reset, a power-on hold keeps the output idle and refuses triggers for `POR_CYCLES` clocks. The trigger lines are assumed to be synchronous to `clk` already. Parameters must satisfy 1 <= `LOCKOUT_CYCLES` < `PERIOD_CYCLES` and `POR_CYCLES` >= 1.

Top module: `mono_pulse_gen`

## Requirements
- R1: A rising edge on `trig_up` is a trigger when `trig_dn` is 1 in the same sample. A rising edge on `trig_up` while `trig_dn` is 0 is ignored.
- R2: A falling edge on `trig_dn` is a trigger when `trig_up` is 0 in the same sample. A falling edge on `trig_dn` while `trig_up` is 1 is ignored. A rise on `trig_up` and a fall on `trig_dn` in the same cycle therefore produce no trigger.
- R3: An accepted trigger sampled at clock edge k makes `pulse_q` 1 after edge k. It stays 1 for exactly `PERIOD_CYCLES` cycles, however long the trigger level is held.
- R4: While `clear_n` is 0, `pulse_q` is 0 in the same cycle, with no clock edge needed. A pulse in progress is abandoned and does not resume when `clear_n` returns to 1. A trigger sampled while `clear_n` is 0 is ignored.
- R5: For the first `POR_CYCLES` clock edges after `rst_n` rises, every trigger is ignored and `pulse_q` stays 0. A trigger at any later edge is accepted.
- R6: Any trigger sampled at the `LOCKOUT_CYCLES` edges that follow an accepted trigger is ignored.
- R7: When `single_shot` is 0, a trigger that comes after the lockout but before the pulse has ended reloads the full period. The pulse then lasts (cycles to the retrigger) + `PERIOD_CYCLES`.
- R8: When `single_shot` is 1, every trigger sampled while `pulse_q` is 1 is ignored. A trigger after the pulse has ended is accepted.
- R9: `pulse_qn` is the complement of `pulse_q` at all times.
- R10: While `rst_n` is 0, `pulse_q` is 0 and `pulse_qn` is 1, and triggers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low register reset; the power-on hold starts when it is released |
| clear_n | input | 1 | Active-low functional clear; forces the output idle and aborts timing |
| trig_up | input | 1 | Rising-edge trigger line, qualified by `trig_dn` high |
| trig_dn | input | 1 | Falling-edge trigger line, qualified by `trig_up` low |
| single_shot | input | 1 | 1 = non-retriggerable, 0 = retriggerable |
| pulse_q | output | 1 | Active-high pulse output |
| pulse_qn | output | 1 | Complement of `pulse_q` |

## Verification
Two events can fall in the same clock cycle: a qualified trigger edge and an active `clear_n`. A trigger can also coincide with the last cycle of the lockout or with the end of the power-on hold. The bench raises `trig_up` while `clear_n` is low and expects no pulse, either then or after the clear is released. It then retriggers on the first edge after the lockout and expects the period to be reloaded. In the power-on test it places a trigger on the last held edge, where it must be refused, and a second trigger two edges later, where it must be accepted.

// File: rtl/mono_pkg.sv
// Package: shared types for the one-shot pulse generator.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package mono_pkg;

    // One sample of the two trigger lines.
    typedef struct packed {
        logic up;   // rising-edge line
        logic dn;   // falling-edge line
    } trig_pair_t;

    // Retrigger behaviour selected by the mode input.
    typedef enum logic {
        MODE_RETRIG = 1'b0,
        MODE_SINGLE = 1'b1
    } retrig_mode_e;

    // Idle levels of the trigger lines; the edge history resets to these.
    localparam trig_pair_t TRIG_IDLE = '{up: 1'b0, dn: 1'b1};

endpackage

// File: rtl/mono_trig_detect.sv
// Trigger detector: finds a qualified rising edge on the up line or a
// qualified falling edge on the down line. The result is combinational.
// Assumes the inputs are already synchronous to clk. The current sample of
// the opposite line does the qualifying, so both edge kinds can never be
// valid together; a coincident pair counts at most once.
module mono_trig_detect
    import mono_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trig_pair_t pins,
    output logic       fire
);

    trig_pair_t prev;
    logic       up_rise;
    logic       dn_fall;

    // Hold last cycle's sample of both lines for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= TRIG_IDLE;
        else        prev <= pins;
    end

    // Qualify each edge by the present level of the other line.
    always_comb begin
        up_rise = pins.up & ~prev.up & pins.dn;
        dn_fall = ~pins.dn & prev.dn & ~pins.up;
        fire    = up_rise | dn_fall;
    end

endmodule

// File: rtl/mono_por_hold.sv
// Power-on hold: after rst_n is released, counts HOLD_CYCLES clock edges and
// only then raises ready. Assumes HOLD_CYCLES >= 1.
module mono_por_hold #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);

    localparam int              CW     = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0]   HOLD_C = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt;

    // Count up once per edge and saturate at the hold length.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt != HOLD_C) cnt <= cnt + 1'b1;
    end

    // The hold is over once the count has saturated.
    always_comb ready = (cnt == HOLD_C);

endmodule

// File: rtl/mono_pulse_timer.sv
// Pulse timer: a period down-counter and a lockout down-counter.
// A trigger is accepted when the hold is over, the clear is inactive, no
// lockout is running, and single mode does not forbid it. An accepted
// trigger loads both counters. Assumes 1 <= LOCKOUT < PERIOD.
module mono_pulse_timer
    import mono_pkg::*;
#(
    parameter int PERIOD  = 100,
    parameter int LOCKOUT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_n,
    input  logic         fire,
    input  logic         ready,
    input  retrig_mode_e mode,
    output logic         accept,
    output logic         active
);

    localparam int            CW       = $clog2(PERIOD + 1);
    localparam int            LW       = $clog2(LOCKOUT + 1);
    localparam logic [CW-1:0] PERIOD_C = CW'(PERIOD);
    localparam logic [LW-1:0] LOCK_C   = LW'(LOCKOUT);

    logic [CW-1:0] remain;
    logic [LW-1:0] lock_cnt;
    logic          locked;
    logic          blocked_by_mode;

    // Decide whether this cycle's trigger is taken.
    always_comb begin
        active          = (remain != '0);
        locked          = (lock_cnt != '0);
        blocked_by_mode = (mode == MODE_SINGLE) && active;
        accept          = fire && ready && clear_n && !locked && !blocked_by_mode;
    end

    // Period counter: reload on accept, count down while running, drop on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !clear_n) remain <= '0;
        else if (accept)        remain <= PERIOD_C;
        else if (active)        remain <= remain - 1'b1;
    end

    // Lockout counter: armed by each accept, drained one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !clear_n) lock_cnt <= '0;
        else if (accept)        lock_cnt <= LOCK_C;
        else if (locked)        lock_cnt <= lock_cnt - 1'b1;
    end

endmodule

// File: rtl/mono_pulse_gen.sv
// Retriggerable one-shot: top level. Wires the trigger detector, the
// power-on hold and the pulse timer together. The output is gated
// combinationally by clear_n and by the hold, so a clear acts within the
// same cycle. Assumes synchronous trigger inputs, 1 <= LOCKOUT_CYCLES <
// PERIOD_CYCLES and POR_CYCLES >= 1.
module mono_pulse_gen
    import mono_pkg::*;
#(
    parameter int PERIOD_CYCLES  = 100,
    parameter int LOCKOUT_CYCLES = 4,
    parameter int POR_CYCLES     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_n,
    input  logic trig_up,
    input  logic trig_dn,
    input  logic single_shot,
    output logic pulse_q,
    output logic pulse_qn
);

    trig_pair_t   pins;
    retrig_mode_e mode;
    logic         fire;
    logic         por_ready;
    logic         start_ok;
    logic         timing;

    // Pack the trigger lines and the mode into package types.
    always_comb begin
        pins = '{up: trig_up, dn: trig_dn};
        mode = retrig_mode_e'(single_shot);
    end

    mono_trig_detect u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (pins),
        .fire  (fire)
    );

    mono_por_hold #(
        .HOLD_CYCLES (POR_CYCLES)
    ) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (por_ready)
    );

    mono_pulse_timer #(
        .PERIOD  (PERIOD_CYCLES),
        .LOCKOUT (LOCKOUT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_n (clear_n),
        .fire    (fire),
        .ready   (por_ready),
        .mode    (mode),
        .accept  (start_ok),
        .active  (timing)
    );

    // Drive the complementary outputs; clear and the hold override the timer.
    always_comb begin
        pulse_q  = timing && clear_n && por_ready;
        pulse_qn = ~pulse_q;
    end

endmodule

// File: rtl/mono_pulse_gen_chk.sv
// Checker for mono_pulse_gen, bound into every instance. It keeps its own
// counters for the power-on window and for the spacing between accepts.
module mono_pulse_gen_chk #(
    parameter int LOCKOUT_CYCLES = 4,
    parameter int POR_CYCLES     = 16
) (
    input logic clk,
    input logic rst_n,
    input logic clear_n,
    input logic single_shot,
    input logic pulse_q,
    input logic start_ok
);

    localparam int            PW     = $clog2(POR_CYCLES + 1);
    localparam logic [PW-1:0] POR_C  = PW'(POR_CYCLES);
    localparam int            LW     = $clog2(LOCKOUT_CYCLES + 1);
    localparam logic [LW-1:0] LOCK_C = LW'(LOCKOUT_CYCLES);

    logic [PW-1:0] since_rst;
    logic [LW-1:0] since_acc;

    // Count edges since reset release, saturating at the hold length.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != POR_C) since_rst <= since_rst + 1'b1;
    end

    // Count edges since the last accept, saturating at the lockout length.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_acc <= LOCK_C;
        else if (start_ok)          since_acc <= '0;
        else if (since_acc != LOCK_C) since_acc <= since_acc + 1'b1;
    end

    // R4
    clear_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |-> !pulse_q);

    // R5
    por_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < POR_C) |-> (!pulse_q && !start_ok));

    // R6
    lockout_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |-> (since_acc == LOCK_C));

    // R3
    accept_raises_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (pulse_q || !clear_n));

    // R8
    single_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (single_shot && pulse_q) |-> !start_ok);

endmodule

bind mono_pulse_gen mono_pulse_gen_chk #(
    .LOCKOUT_CYCLES (LOCKOUT_CYCLES),
    .POR_CYCLES     (POR_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_n     (clear_n),
    .single_shot (single_shot),
    .pulse_q     (pulse_q),
    .start_ok    (start_ok)
);

// File: tb/tb_mono_pulse_gen.sv
// Bench for mono_pulse_gen: a per-cycle vector table, then directed tests.
module tb_mono_pulse_gen;

    localparam int CLK_PERIOD = 10;
    localparam int P   = 6;
    localparam int L   = 2;
    localparam int POR = 4;
    localparam int NV  = 39;

    logic clk = 1'b0;
    logic rst_n, clear_n, trig_up, trig_dn, single_shot;
    logic pulse_q, pulse_qn;
    int   n_tests = 0;
    int   n_fail  = 0;

    // Vector fields {up, dn, clear_n, single_shot, expected q after the edge}.
    localparam logic [4:0] VEC [NV] = '{
        5'b11101, 5'b11101, 5'b01101, 5'b01101, 5'b01101, 5'b01101, 5'b01100, // R3: 0..6
        5'b10100, 5'b00100, 5'b10100, 5'b11100, 5'b10100, 5'b00100, 5'b01100, // R1 R2: 7..13
        5'b00101, 5'b11101, 5'b01101, 5'b11101, 5'b01101, 5'b01101, 5'b01101,
        5'b01101, 5'b01101, 5'b01100,                                         // R6 R7: 14..23
        5'b11111, 5'b01111, 5'b01111, 5'b11111, 5'b01111, 5'b01111, 5'b01110,
        5'b11111,                                                             // R8: 24..31
        5'b11000, 5'b01100, 5'b11000, 5'b11100, 5'b01100, 5'b11101, 5'b01101  // R4: 32..38
    };

    mono_pulse_gen #(
        .PERIOD_CYCLES  (P),
        .LOCKOUT_CYCLES (L),
        .POR_CYCLES     (POR)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_n     (clear_n),
        .trig_up     (trig_up),
        .trig_dn     (trig_dn),
        .single_shot (single_shot),
        .pulse_q     (pulse_q),
        .pulse_qn    (pulse_qn)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string tag_of(int i);
        if (i < 7)       return "R3";
        else if (i < 14) return "R1/R2";
        else if (i < 24) return "R6/R7";
        else if (i < 32) return "R8";
        else             return "R4";
    endfunction

    // Compare both outputs with the expected q; qn covers R9.
    task automatic chk(string tag, logic exp_q);
        n_tests++;
        if (pulse_q !== exp_q) begin
            n_fail++;
            $display("FAIL %s: pulse_q=%b expected %b at %0t", tag, pulse_q, exp_q, $time);
        end
        n_tests++;
        if (pulse_qn !== ~exp_q) begin
            n_fail++;
            $display("FAIL R9 (%s): pulse_qn=%b expected %b at %0t", tag, pulse_qn, ~exp_q, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; clear_n = 1'b1; trig_up = 1'b0; trig_dn = 1'b1; single_shot = 1'b0;
        step(); step();
        chk("R10 reset state", 1'b0);
        trig_up = 1'b1;
        step();
        chk("R10 trigger in reset", 1'b0);
        trig_up = 1'b0;
        step();

        // R5: power-on hold; the trigger on the last held edge is refused.
        rst_n = 1'b1;
        for (int k = 0; k < POR - 1; k++) begin
            step();
            chk("R5 hold idle", 1'b0);
        end
        trig_up = 1'b1;
        step();
        chk("R5 last held edge", 1'b0);
        trig_up = 1'b0;
        step();
        trig_up = 1'b1;
        step();
        chk("R5 after hold", 1'b1);
        trig_up = 1'b0;
        for (int k = 0; k < P; k++) step();
        chk("R5 pulse ended", 1'b0);

        // Table walk: one vector per clock.
        for (int i = 0; i < NV; i++) begin
            {trig_up, trig_dn, clear_n, single_shot} = VEC[i][4:1];
            step();
            chk(tag_of(i), VEC[i][0]);
        end

        // R4: clear acts within the cycle, before any edge.
        clear_n = 1'b0;
        #1;
        chk("R4 immediate clear", 1'b0);
        step();
        clear_n = 1'b1;
        step();
        chk("R4 pulse aborted", 1'b0);
        step();
        chk("R4 stays idle", 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule